// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a byte presented in parallel into a bit stream. While the active-low load control is held low, every rising edge of the system clock copies all eight parallel inputs into the register at once. While the load control is high and the inhibit input is low, each rising edge moves every stored bit one stage toward the output. A new bit enters the first stage from a serial input.

The last stage drives a true serial output and its complement. The inhibit input is combined with the clock, so a high inhibit freezes the register while no load is pending. A load takes priority over both shifting and inhibit.

Because the first stage is fed from a serial input, two or more units can be chained into a longer register. Each unit's serial input is tied to the serial output of the unit before it. All units share the clock, the load control and the inhibit input.

Top module: `piso_shreg`

## Requirements
- R1: While the active-low reset `rst_n` is low, all stages clear, so `ser_out` is 0 and `ser_out_n` is 1.
- R2: A rising edge with `ld_n` low stores `par_in` in all stages. From that edge on, `ser_out` equals `par_in[7]`.
- R3: A load takes effect even when `inh` is high.
- R4: A rising edge with `ld_n` high and `inh` low moves each stage's bit one place toward the output. After a load, `ser_out` therefore presents `par_in[7]`, then `par_in[6]`, and so on down to `par_in[0]`, one bit per shifting edge.
- R5: On each shifting edge the first stage takes `ser_in`. After eight more shifting edges, the bits fed in appear on `ser_out` in the order they were fed.
- R6: A rising edge with `ld_n` high and `inh` high leaves every stage unchanged, so `ser_out` holds its value whatever `ser_in` does.
- R7: `ser_out_n` is always the complement of `ser_out`.
- R8: Two units are chained, with the downstream unit's `ser_in` fed from the upstream unit's `ser_out`. A shared load followed by 16 shifts puts the downstream byte on the downstream `ser_out` first, MSB first, and then the upstream byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Parallel load when low, shift/hold when high |
| inh | input | 1 | Clock inhibit; high blocks shifting |
| par_in | input | 8 | Parallel data; bit 7 leaves first |
| ser_in | input | 1 | Serial data into the first stage |
| ser_out | output | 1 | Last stage, true polarity |
| ser_out_n | output | 1 | Last stage, complemented |

## Verification
The bench loads with inhibit raised. A design that let inhibit block the load would keep the old byte. The bench also holds inhibit high for several cycles while `ser_in` toggles: a design that leaked `ser_in` into the first stage, or that shifted anyway, shows a wrong bit later in the stream. A two-unit chain is shifted 16 and then 24 times. This catches a reversed bit order, a dropped or extra stage, and a first stage that ignores `ser_in`, because each of these mis-orders or corrupts the downstream byte, the upstream byte or the trailing serial bits. The complement output is compared on every cycle, including during reset.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Operation applied to every stage on the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } op_e;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic ld_n,
    input  logic inh,
    output op_e  op
);

    // Load dominates; inhibit is OR-ed with the clock and only gates shifting
    always_comb begin
        if (!ld_n) begin
            op = OP_LOAD;
        end else if (inh) begin
            op = OP_HOLD;
        end else begin
            op = OP_SHIFT;
        end
    end

endmodule

// File: rtl/piso_stage.sv
module piso_stage
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic par_bit,
    input  logic prev_bit,
    output logic bit_o
);

    typedef struct packed {
        logic val;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.val = par_bit;
            OP_SHIFT: st_d.val = prev_bit;
            default:  st_d.val = st_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.val;

    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (bit_o == $past(par_bit))); // R2
    AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (bit_o == $past(prev_bit))); // R4
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(bit_o)); // R6

endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_n,
    input  logic             inh,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             ser_out_n
);

    localparam int LAST = WIDTH - 1;

    op_e              op;
    logic [WIDTH:0]   chain;

    piso_ctrl u_ctrl (
        .ld_n (ld_n),
        .inh  (inh),
        .op   (op)
    );

    // chain[0] feeds the first stage; chain[i+1] is stage i
    assign chain[0] = ser_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
        piso_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (op),
            .par_bit  (par_in[gi]),
            .prev_bit (chain[gi]),
            .bit_o    (chain[gi+1])
        );
    end

    assign ser_out   = chain[WIDTH];
    assign ser_out_n = ~chain[WIDTH];

    AST_LOAD_OVER_INH: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && inh) |=> (ser_out == $past(par_in[LAST]))); // R3
    AST_INH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && inh) |=> $stable(ser_out)); // R6
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !inh) |=> (ser_out == $past(g_stage[LAST-1].u_stage.bit_o))); // R4

endmodule

// File: tb/piso_shreg_tb.sv
`timescale 1ns/1ps
module piso_shreg_tb_top;

    typedef struct {
        string req;
        logic  exp_dn;
        logic  exp_up;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_n = 1'b1;
    logic       inh = 1'b0;
    logic [7:0] par_up = 8'h00;
    logic [7:0] par_dn = 8'h00;
    logic       ser_in = 1'b0;
    logic       up_out, up_out_n, dn_out, dn_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    item_t      sb_q[$];
    logic [7:0] m_up = 8'h00;
    logic [7:0] m_dn = 8'h00;

    always #2.5 clk = ~clk;

    piso_shreg #(.WIDTH(8)) dut_up_i (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .inh(inh),
        .par_in(par_up), .ser_in(ser_in),
        .ser_out(up_out), .ser_out_n(up_out_n)
    );

    piso_shreg #(.WIDTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .inh(inh),
        .par_in(par_dn), .ser_in(up_out),
        .ser_out(dn_out), .ser_out_n(dn_out_n)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Monitor: pops the expected item for the last edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.req, dn_out, it.exp_dn);
            check(it.req, up_out, it.exp_up);
            check("R7", dn_out_n, ~dn_out);
            check("R7", up_out_n, ~up_out);
        end
    end

    // Driver: applies one cycle, advances the model, pushes the expectation
    task automatic step(logic l, logic ih, logic [7:0] pu, logic [7:0] pd,
                        logic si, string req);
        logic [7:0] nu, nd;
        item_t it;
        @(negedge clk);
        #0.5;
        ld_n = l; inh = ih; par_up = pu; par_dn = pd; ser_in = si;
        nu = m_up; nd = m_dn;
        if (!l) begin
            nu = pu; nd = pd;
        end else if (!ih) begin
            nd = {m_dn[6:0], m_up[7]};
            nu = {m_up[6:0], si};
        end
        m_up = nu; m_dn = nd;
        @(posedge clk);
        #1;
        it.req = req; it.exp_dn = m_dn[7]; it.exp_up = m_up[7];
        sb_q.push_back(it);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pat;
        repeat (3) @(negedge clk);
        check("R1", dn_out, 1'b0);
        check("R1", dn_out_n, 1'b1);
        check("R1", up_out, 1'b0);
        check("R1", up_out_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: plain load, then R4 shift order
        step(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, "R2");
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 8'hFF, 8'hFF, 1'b1, "R4");

        // R6: inhibit freezes while ser_in and par_in toggle
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'h00, 8'hFF, i[0], "R6");
        step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R6");

        // R3: load with inhibit raised
        step(1'b0, 1'b1, 8'h5A, 8'hC3, 1'b1, "R3");
        step(1'b1, 1'b1, 8'h00, 8'h00, 1'b1, "R3");

        // R8: 16 shifts across the chain, feeding a known pattern
        pat = 8'b1011_0010;
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 8'h00, 8'h00, pat[7 - (i % 8)], "R8");
        // R5: fed bits emerge in order
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R5");

        // R2/R4 with single-bit patterns
        step(1'b0, 1'b0, 8'h01, 8'h80, 1'b0, "R2");
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R4");

        // R1: reset mid-stream
        step(1'b0, 1'b0, 8'hFF, 8'hFF, 1'b1, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", dn_out, 1'b0);
        check("R1", up_out, 1'b0);
        check("R1", dn_out_n, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule